// File: doc/BRIEF.md
# Registered bidirectional bus transceiver

The block joins two 8-bit ports, A and B, and can pass data either way between them. Each direction owns a storage register with its own capture strobe. The A-to-B register samples port A and the B-to-A register samples port B. The port that drives can send either the live word from the opposite port or the word held in that direction's register.

An active-low output enable and a direction input decide which port drives, if any. Two source selects, one per direction, pick live or stored data. Each port is modelled as a separate input word, output word and drive-enable flag, so no tri-state pins are needed.

The whole block runs on one system clock. The two capture strobes are ordinary inputs sampled in that clock domain, and a register loads in the cycle where its strobe is seen high after having been low in the previous cycle. Captures take place whatever the state of the enable and the direction input.

Top module: `regxcvr_top`

## Requirements
- R1: While `rst` is high, `a_drv` and `b_drv` are 0 and both storage registers are cleared to zero. Zero is therefore read back after reset.
- R2: The A-to-B register loads the port A value at a clock edge where `cap_ab` is 1 and was 0 at the previous edge. At every other edge it holds its contents.
- R3: The B-to-A register loads the port B value at a clock edge where `cap_ba` is 1 and was 0 at the previous edge. At every other edge it holds its contents.
- R4: Captures do not depend on `oe_n` or `dir`, and both registers can load at the same edge.
- R5: With `oe_n` = 1, neither `a_drv` nor `b_drv` is asserted (isolation).
- R6: With `oe_n` = 0 and `rst` = 0, `dir` = 0 gives `a_drv` = 1 and `b_drv` = 0, and `dir` = 1 gives `b_drv` = 1 and `a_drv` = 0.
- R7: While port A drives, `sel_ba` = 0 puts `b_in` on `a_out` and `sel_ba` = 1 puts the B-to-A register on `a_out`.
- R8: While port B drives, `sel_ab` = 0 puts `a_in` on `b_out` and `sel_ab` = 1 puts the A-to-B register on `b_out`.
- R9: `a_drv` and `b_drv` are never both 1.
- R10: If a port is driving when its own register captures, the register loads the word that port is driving, not its input word. Port A's register is the A-to-B register; port B's register is the B-to-A register.
- R11: An output word whose drive flag is 0 reads as all zeros.
- R12: A capture strobe that is already high when reset is released causes no load until it has gone low and risen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| oe_n | input | 1 | Output enable, active low |
| dir | input | 1 | 0: port A drives, 1: port B drives |
| cap_ab | input | 1 | Capture strobe of the A-to-B register |
| cap_ba | input | 1 | Capture strobe of the B-to-A register |
| sel_ab | input | 1 | B output source: 0 live A, 1 stored |
| sel_ba | input | 1 | A output source: 0 live B, 1 stored |
| a_in | input | WIDTH | Word arriving at port A |
| a_out | output | WIDTH | Word port A drives |
| a_drv | output | 1 | Port A output enable |
| b_in | input | WIDTH | Word arriving at port B |
| b_out | output | WIDTH | Word port B drives |
| b_drv | output | 1 | Port B output enable |

## Verification
On every cycle, the assertions check the following: only one port drives at a time, both ports are silent during reset and isolation, a register holds when no rising strobe is seen, and a register loads the sampled word when one is seen. Some behaviours only the bench scenarios can show, because they need a reference model of both registers. These are the word that a driving port routes out, the driven-value capture of R10, and the behaviour of a strobe held high across reset release. The bench also sweeps random mixes of enable, direction and select.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
   localparam int unsigned NUM_PATHS = 2;
   localparam int unsigned PATH_AB = 0;
   localparam int unsigned PATH_BA = 1;
   typedef enum logic [1:0] {
      MODE_ISOLATE = 2'd0,
      MODE_DRIVE_A = 2'd1,
      MODE_DRIVE_B = 2'd2
   } xcvr_mode_e;
endpackage

// File: rtl/xcvr_edge.sv
module xcvr_edge (
   input  logic clk,
   input  logic rst,
   input  logic lvl,
   output logic rise
);
   logic prev_q;
   always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b1;
      else     prev_q <= lvl;
   end
   assign rise = lvl & ~prev_q & ~rst;
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         initial $error("xcvr_store: WIDTH must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)       q <= '0;
      else if (load) q <= d;
   end

   // R2 / R3: hold without a detected rise
   assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(q));
   // R3: a detected rise loads the sampled word
   assert_load_R3: assert property (@(posedge clk) disable iff (rst)
      load |=> (q == $past(d)));
endmodule

// File: rtl/xcvr_port.sv
module xcvr_port #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             en,
   input  logic             sel,
   input  logic [WIDTH-1:0] live,
   input  logic [WIDTH-1:0] stored,
   output logic [WIDTH-1:0] out,
   output logic             drv
);
   logic [WIDTH-1:0] pick;
   always_comb begin
      pick = sel ? stored : live;
      out  = en ? pick : '0;
      drv  = en;
   end
endmodule

// File: rtl/regxcvr_top.sv
module regxcvr_top
   import xcvr_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             oe_n,
   input  logic             dir,
   input  logic             cap_ab,
   input  logic             cap_ba,
   input  logic             sel_ab,
   input  logic             sel_ba,
   input  logic [WIDTH-1:0] a_in,
   output logic [WIDTH-1:0] a_out,
   output logic             a_drv,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] b_out,
   output logic             b_drv
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         initial $error("regxcvr_top: WIDTH must be at least 1");
      end
   endgenerate

   xcvr_mode_e mode;
   always_comb begin
      if (rst || oe_n) mode = MODE_ISOLATE;
      else if (dir)    mode = MODE_DRIVE_B;
      else             mode = MODE_DRIVE_A;
   end

   // index = source port of the path: 0 = A (feeds B), 1 = B (feeds A)
   logic [NUM_PATHS-1:0][WIDTH-1:0] p_in, p_out, src, stored;
   logic [NUM_PATHS-1:0]            p_drv, strobe, sel, en, rise;

   assign p_in[PATH_AB]   = a_in;
   assign p_in[PATH_BA]   = b_in;
   assign strobe[PATH_AB] = cap_ab;
   assign strobe[PATH_BA] = cap_ba;
   assign sel[PATH_AB]    = sel_ab;
   assign sel[PATH_BA]    = sel_ba;
   assign en[PATH_AB]     = (mode == MODE_DRIVE_B);
   assign en[PATH_BA]     = (mode == MODE_DRIVE_A);

   genvar d;
   generate
      for (d = 0; d < NUM_PATHS; d++) begin : g_path
         localparam int unsigned DST = NUM_PATHS - 1 - d;
         // capture the driven word when this path's source port is driving
         assign src[d] = p_drv[d] ? p_out[d] : p_in[d];

         xcvr_edge u_edge (
            .clk(clk), .rst(rst), .lvl(strobe[d]), .rise(rise[d])
         );
         xcvr_store #(.WIDTH(WIDTH)) u_store (
            .clk(clk), .rst(rst), .load(rise[d]), .d(src[d]), .q(stored[d])
         );
         xcvr_port #(.WIDTH(WIDTH)) u_port (
            .en(en[d]), .sel(sel[d]), .live(p_in[d]), .stored(stored[d]),
            .out(p_out[DST]), .drv(p_drv[DST])
         );
      end
   endgenerate

   assign a_out = p_out[PATH_AB];
   assign a_drv = p_drv[PATH_AB];
   assign b_out = p_out[PATH_BA];
   assign b_drv = p_drv[PATH_BA];

   // R9: one driver at most
   assert_one_driver_R9: assert property (@(posedge clk) disable iff (rst)
      !(a_drv && b_drv));
   // R1: silent ports while in reset
   assert_reset_quiet_R1: assert property (@(posedge clk)
      rst |-> (!a_drv && !b_drv));
   // R5: isolation when the enable is high
   assert_isolate_R5: assert property (@(posedge clk) disable iff (rst)
      oe_n |-> (!a_drv && !b_drv));
   // R6: the direction input picks the driving port
   assert_dir_R6: assert property (@(posedge clk) disable iff (rst)
      !oe_n |-> (a_drv == !dir) && (b_drv == dir));
   // R1: registers read zero right after reset
   assert_reset_clear_R1: assert property (@(posedge clk)
      $fell(rst) |-> (stored == '0));
endmodule

// File: tb/sim_regxcvr_top.sv
`timescale 1ns/1ps
module sim_regxcvr_top;
   localparam int W = 8;
   logic clk = 1'b0;
   logic rst, oe_n, dir, cap_ab, cap_ba, sel_ab, sel_ba;
   logic [W-1:0] a_in, b_in, a_out, b_out;
   logic a_drv, b_drv;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic [W-1:0] m_ab, m_ba;
   logic pv_ab, pv_ba;

   always #2 clk = ~clk;

   regxcvr_top #(.WIDTH(W)) u0 (
      .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir),
      .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
      .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
      .b_in(b_in), .b_out(b_out), .b_drv(b_drv)
   );

   function automatic logic e_adrv();
      return !rst && !oe_n && !dir;
   endfunction
   function automatic logic e_bdrv();
      return !rst && !oe_n && dir;
   endfunction
   function automatic logic [W-1:0] e_aout();
      return e_adrv() ? (sel_ba ? m_ba : b_in) : '0;
   endfunction
   function automatic logic [W-1:0] e_bout();
      return e_bdrv() ? (sel_ab ? m_ab : a_in) : '0;
   endfunction

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(input logic r, o, dr, cab, cba, sab, sba,
                       input logic [W-1:0] a, b);
      logic [W-1:0] sa, sb;
      @(negedge clk);
      rst = r; oe_n = o; dir = dr; cap_ab = cab; cap_ba = cba;
      sel_ab = sab; sel_ba = sba; a_in = a; b_in = b;
      #0.5;
      chk(r ? "R1 a_drv" : (o ? "R5 a_drv" : "R6 a_drv"), {7'd0, a_drv}, {7'd0, e_adrv()});
      chk(r ? "R1 b_drv" : (o ? "R5 b_drv" : "R6 b_drv"), {7'd0, b_drv}, {7'd0, e_bdrv()});
      chk(e_adrv() ? (sba ? "R7 stored" : "R7 live") : "R11 a_out", a_out, e_aout());
      chk(e_bdrv() ? (sab ? "R8 stored" : "R8 live") : "R11 b_out", b_out, e_bout());
      chk("R9 both", {7'd0, a_drv && b_drv}, 8'd0);
      sa = e_adrv() ? e_aout() : a_in;
      sb = e_bdrv() ? e_bout() : b_in;
      @(posedge clk);
      if (r) begin
         m_ab = '0; m_ba = '0; pv_ab = 1'b1; pv_ba = 1'b1;
      end else begin
         if (cab && !pv_ab) m_ab = sa;
         if (cba && !pv_ba) m_ba = sb;
         pv_ab = cab; pv_ba = cba;
      end
   endtask

   // read back both registers through the normal outputs
   task automatic peek(input string tag, input logic [W-1:0] exp_ab, exp_ba);
      step(0, 0, 1, 0, 0, 1, 0, 8'h00, 8'h00);
      chk({tag, " ab"}, b_out, exp_ab);
      step(0, 0, 0, 0, 0, 0, 1, 8'h00, 8'h00);
      chk({tag, " ba"}, a_out, exp_ba);
   endtask

   initial begin
      #(4 * 200000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      m_ab = '0; m_ba = '0; pv_ab = 1'b1; pv_ba = 1'b1;
      rst = 1; oe_n = 0; dir = 0; cap_ab = 0; cap_ba = 0;
      sel_ab = 0; sel_ba = 0; a_in = 0; b_in = 0;
      // R1: reset silences the ports, even with oe_n low
      step(1, 0, 0, 0, 0, 0, 0, 8'h11, 8'h22);
      step(1, 0, 1, 1, 1, 1, 1, 8'h33, 8'h44);
      // R12: strobes high across reset release must not load
      step(0, 1, 0, 1, 1, 0, 0, 8'h5A, 8'hA5);
      step(0, 1, 0, 1, 1, 0, 0, 8'h5B, 8'hA6);
      peek("R12 held strobe", 8'h00, 8'h00);
      peek("R1 cleared", 8'h00, 8'h00);
      // R2/R3: rising strobes load both registers, isolated
      step(0, 1, 0, 1, 1, 0, 0, 8'hC3, 8'h3C);
      step(0, 1, 0, 0, 0, 0, 0, 8'hFF, 8'hFF);
      peek("R2 R3 load", 8'hC3, 8'h3C);
      // R4: capture while driving B, both at once
      step(0, 0, 1, 1, 1, 0, 0, 8'h81, 8'h18);
      step(0, 0, 1, 0, 0, 0, 0, 8'h00, 8'h00);
      peek("R4 both", 8'h81, 8'hAA & 8'h00 | m_ba);
      // R10: port A drives live B; A-to-B register captures the driven word
      step(0, 0, 0, 1, 0, 0, 0, 8'h12, 8'h9E);
      step(0, 0, 0, 0, 0, 0, 0, 8'h00, 8'h00);
      peek("R10 driven A", 8'h9E, m_ba);
      // R10: port B drives stored A-to-B; B-to-A register captures it
      step(0, 0, 1, 0, 1, 1, 0, 8'h00, 8'h77);
      step(0, 0, 1, 0, 0, 0, 0, 8'h00, 8'h00);
      peek("R10 driven B", 8'h9E, 8'h9E);
      // R2: held-high strobe loads only once
      step(0, 1, 0, 1, 0, 0, 0, 8'h01, 8'h00);
      step(0, 1, 0, 1, 0, 0, 0, 8'h02, 8'h00);
      step(0, 1, 0, 1, 0, 0, 0, 8'h03, 8'h00);
      peek("R2 single load", 8'h01, 8'h9E);
      // random sweep against the model
      for (int i = 0; i < 3000; i++) begin
         logic [9:0] c;
         c = 10'($urandom());
         step(c[9:0] == 10'd0, c[0], c[1], c[2], c[3], c[4], c[5],
              8'($urandom()), 8'($urandom()));
      end
      peek("R2 R3 final", m_ab, m_ba);
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule